// File: doc/BRIEF.md
# SoC-to-Host Reverse Window Lookup

This block answers one question for the host-facing side of a chip: given a 58-bit SoC-absolute address, which host BAR window (if any) exposes it, and at what byte offset inside that BAR does it appear? The SoC address space is sparse: die copies sit far apart, and a chip id field marks the owning device. The host BARs, by contrast, pack their windows densely. The block holds a small table of windows. Each window has a BAR id, a SoC base, a host offset and a size. The table is filled through a dedicated write port with the same entries that the forward (host-to-SoC) translator uses. Each lookup returns a registered result one cycle later.

Two attribute flags can be ORed into the upper address bits of a request: bit 56 requests relaxed ordering, and bit 57 marks the access as allowed to fail. Both flags are stripped before any window comparison. The chip id (bits 53:48), its valid flag (bit 54) and the die select (bit 47) are kept. They take part in the comparison as ordinary address bits, because every window base already carries them. When several windows cover the same address, the entry with the lowest index wins. An address that no window covers reports a miss, and the BAR id and offset are then zero.

Top module: `soc2bar_window_lookup`

## Requirements
- R1: While reset is asserted, `rspValid` is 0. Reset disables every table entry, so any lookup made before an entry is written returns a miss.
- R2: Bits 56 and 57 of `reqAddr` are cleared before comparison. Setting either or both gives exactly the same hit, BAR id and offset as the same address without them.
- R3: A window matches only when its enable is set and the masked address lies in the half-open range [socBase, socBase + size). Address socBase + size − 1 matches, socBase + size does not, and socBase − 1 does not.
- R4: On a hit, `rspHit` is 1, `rspBar` is the window's BAR id, and `rspOffset` equals hostOff + (masked address − socBase), truncated to 40 bits.
- R5: On a miss, `rspHit`, `rspBar` and `rspOffset` are all 0.
- R6: `rspValid` is 1 exactly in the cycle after a cycle with `reqValid` high, and 0 otherwise. Back-to-back requests give back-to-back responses in order. When `rspValid` is 0, the other response outputs are 0.
- R7: When more than one enabled window matches, the lowest-indexed one supplies the result.
- R8: Bits 53:48 (chip id), bit 54 (chip-id valid) and bit 47 (die select) are compared like other address bits. An address that differs from a window's range only in one of these bits does not match that window.
- R9: A table write with `tblWrEn` high stores the entry at `tblWrIdx` (enable, BAR id, SoC base, host offset, size). A lookup in the same cycle still sees the old entry. Lookups from the next cycle on see the new entry. Writing enable 0 removes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | 3 | Entry index to write |
| tblWrValid | input | 1 | Enable flag of the written entry |
| tblWrBar | input | 3 | BAR id of the written entry |
| tblWrSocBase | input | 58 | SoC-absolute base of the written entry |
| tblWrHostOff | input | 40 | Host offset inside the BAR of the written entry |
| tblWrSize | input | 40 | Window size in bytes of the written entry |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 58 | SoC address to look up, attribute bits allowed |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspHit | output | 1 | 1 if a window exposes the address |
| rspBar | output | 3 | BAR id of the selected window, 0 on miss |
| rspOffset | output | 40 | Byte offset inside the BAR, 0 on miss |

## Verification
Corruption of a table entry or a wrong comparison shows up at the ports on the first lookup that lands inside or next to that window. The response arrives one cycle later, either with the wrong BAR id or offset, or with a hit where a miss was due. The bench therefore probes both edges of a window, an address just outside each edge, and a request in the same cycle as a table rewrite. If the request pipeline register slips, a response appears with no request or goes missing, which the scoreboard catches in the very next cycle. If attribute masking is broken, a flagged address gives a different result from the unflagged one at the response for that request.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  parameter int ADDR_W    = 58;  // SoC-absolute address width
  parameter int OFF_W     = 40;  // host offset / window size width
  parameter int BAR_W     = 3;   // BAR id width
  parameter int ATTR_LO   = 56;  // lowest attribute flag bit
  parameter int ATTR_BITS = 2;   // relaxed-ordering and ok-to-fail flags

  localparam logic [ADDR_W-1:0] ATTR_MASK =
    ADDR_W'(((64'd1 << ATTR_BITS) - 64'd1) << ATTR_LO);

  typedef struct packed {
    logic              en;
    logic [BAR_W-1:0]  bar;
    logic [ADDR_W-1:0] socBase;
    logic [OFF_W-1:0]  hostOff;
    logic [OFF_W-1:0]  size;
  } win_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tblWrite;
    logic capture;
  } ctl_t;

  typedef struct packed {
    logic             hit;
    logic [BAR_W-1:0] bar;
    logic [OFF_W-1:0] offset;
  } rsp_t;
endpackage

// File: rtl/lkp_ctrl.sv
module lkp_ctrl
  import lkp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tblWrEn,
  input  logic reqValid,
  output ctl_t ctl,
  output logic rspValid
);
  always_comb begin
    ctl.tblWrite = tblWrEn;
    ctl.capture  = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/lkp_datapath.sv
module lkp_datapath
  import lkp_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  win_t              wrEntry,
  input  logic [ADDR_W-1:0] reqAddr,
  output rsp_t              rsp
);
  win_t              tbl     [NUM_WIN];
  logic [ADDR_W-1:0] diff    [NUM_WIN];
  logic [OFF_W-1:0]  candOff [NUM_WIN];
  logic [NUM_WIN-1:0] hitVec;
  logic [ADDR_W-1:0] masked;
  rsp_t              nxt;

  assign masked = reqAddr & ~ATTR_MASK;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) tbl[i] <= '0;
      else if (ctl.tblWrite && wrIdx == IDX_W'(i)) tbl[i] <= wrEntry;
    end

    always_comb begin
      diff[i]    = masked - tbl[i].socBase;
      hitVec[i]  = tbl[i].en && (masked >= tbl[i].socBase) &&
                   (diff[i] < ADDR_W'(tbl[i].size));
      candOff[i] = tbl[i].hostOff + diff[i][OFF_W-1:0];
    end
  end

  // lowest index wins: scan downward, later assignment overrides
  always_comb begin
    nxt = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        nxt.hit    = 1'b1;
        nxt.bar    = tbl[i].bar;
        nxt.offset = candOff[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rsp <= '0;
    else if (ctl.capture) rsp <= nxt;
    else                  rsp <= '0;
  end
endmodule

// File: rtl/soc2bar_window_lookup.sv
module soc2bar_window_lookup
  import lkp_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic              tblWrValid,
  input  logic [BAR_W-1:0]  tblWrBar,
  input  logic [ADDR_W-1:0] tblWrSocBase,
  input  logic [OFF_W-1:0]  tblWrHostOff,
  input  logic [OFF_W-1:0]  tblWrSize,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [BAR_W-1:0]  rspBar,
  output logic [OFF_W-1:0]  rspOffset
);
  ctl_t ctl;
  rsp_t rsp;
  win_t wrEntry;

  always_comb begin
    wrEntry.en      = tblWrValid;
    wrEntry.bar     = tblWrBar;
    wrEntry.socBase = tblWrSocBase;
    wrEntry.hostOff = tblWrHostOff;
    wrEntry.size    = tblWrSize;
  end

  lkp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .reqValid(reqValid),
    .ctl(ctl), .rspValid(rspValid)
  );

  lkp_datapath #(.NUM_WIN(NUM_WIN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(tblWrIdx),
    .wrEntry(wrEntry), .reqAddr(reqAddr), .rsp(rsp)
  );

  assign rspHit    = rsp.hit;
  assign rspBar    = rsp.bar;
  assign rspOffset = rsp.offset;
endmodule

// File: rtl/soc2bar_window_lookup_chk.sv
module soc2bar_window_lookup_chk
  import lkp_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              tblWrEn,
  input logic [IDX_W-1:0]  tblWrIdx,
  input logic              tblWrValid,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic [BAR_W-1:0]  rspBar,
  input logic [OFF_W-1:0]  rspOffset
);
  logic anyEntry;
  always_ff @(posedge clk) begin
    if (!rstN) anyEntry <= 1'b0;
    else if (tblWrEn && tblWrValid) anyEntry <= 1'b1;
  end

  // R1: no entry has ever been enabled, so a lookup cannot hit
  p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !$past(anyEntry) |-> !rspHit);

  // R6: response strobe follows the request by exactly one cycle
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && rspBar == '0 && rspOffset == '0));

  // R5: a miss carries no BAR id and no offset
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> (rspBar == '0 && rspOffset == '0));

  // R2: back-to-back requests equal after masking give equal results
  p_attr_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid) && !$past(tblWrEn) &&
     ((reqAddr & ~ATTR_MASK) == ($past(reqAddr) & ~ATTR_MASK)))
    |=> (rspHit == $past(rspHit) && rspBar == $past(rspBar) &&
         rspOffset == $past(rspOffset)));
endmodule

bind soc2bar_window_lookup soc2bar_window_lookup_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
  .tblWrValid(tblWrValid), .reqValid(reqValid), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspHit(rspHit), .rspBar(rspBar), .rspOffset(rspOffset)
);

// File: tb/test_soc2bar_window_lookup.sv
module test_soc2bar_window_lookup;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tblWrEn;
  logic [2:0]  tblWrIdx;
  logic        tblWrValid;
  logic [2:0]  tblWrBar;
  logic [57:0] tblWrSocBase;
  logic [39:0] tblWrHostOff;
  logic [39:0] tblWrSize;
  logic        reqValid;
  logic [57:0] reqAddr;
  logic        rspValid;
  logic        rspHit;
  logic [2:0]  rspBar;
  logic [39:0] rspOffset;

  always #4 clk = ~clk;  // 125 MHz

  soc2bar_window_lookup i_soc2bar_window_lookup (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrValid(tblWrValid), .tblWrBar(tblWrBar), .tblWrSocBase(tblWrSocBase),
    .tblWrHostOff(tblWrHostOff), .tblWrSize(tblWrSize), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit), .rspBar(rspBar),
    .rspOffset(rspOffset)
  );

  int nCmp = 0;
  int nBad = 0;

  // bench-side window model
  logic        mEn   [NW];
  logic [2:0]  mBar  [NW];
  logic [57:0] mBase [NW];
  logic [39:0] mHost [NW];
  logic [39:0] mSize [NW];

  logic [43:0] expQ [$];   // {hit, bar, offset}
  string       tagQ [$];

  localparam logic [57:0] B56 = 58'h1 << 56;
  localparam logic [57:0] B57 = 58'h1 << 57;

  function automatic logic [43:0] model(input logic [57:0] a);
    logic [57:0] m;
    logic [57:0] d;
    m = a & ~(B56 | B57);
    for (int i = 0; i < NW; i++) begin
      d = m - mBase[i];
      if (mEn[i] && m >= mBase[i] && d < {18'b0, mSize[i]})
        return {1'b1, mBar[i], mHost[i] + d[39:0]};
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: one request per call, left high; caller idles when done
  task automatic req(input logic [57:0] a, input string tag);
    reqValid = 1'b1;
    reqAddr  = a;
    expQ.push_back(model(a));
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    reqAddr  = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setWr(input int idx, input logic en, input logic [2:0] bar,
                       input logic [57:0] base, input logic [39:0] host,
                       input logic [39:0] size);
    tblWrEn = 1'b1; tblWrIdx = 3'(idx); tblWrValid = en; tblWrBar = bar;
    tblWrSocBase = base; tblWrHostOff = host; tblWrSize = size;
  endtask

  task automatic commitWr(input int idx);
    mEn[idx] = tblWrValid; mBar[idx] = tblWrBar; mBase[idx] = tblWrSocBase;
    mHost[idx] = tblWrHostOff; mSize[idx] = tblWrSize;
    tblWrEn = 1'b0;
  endtask

  task automatic wrWin(input int idx, input logic en, input logic [2:0] bar,
                       input logic [57:0] base, input logic [39:0] host,
                       input logic [39:0] size);
    setWr(idx, en, bar, base, host, size);
    @(negedge clk);
    commitWr(idx);
  endtask

  // monitor: compare each response with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 response without request", 64'(rspValid), 64'd0);
      end else begin
        logic [43:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({rspHit, rspBar, rspOffset} == e, t,
              64'({rspHit, rspBar, rspOffset}), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    nCmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      mEn[i] = 1'b0; mBar[i] = '0; mBase[i] = '0; mHost[i] = '0; mSize[i] = '0;
    end
    rstN = 1'b0; tblWrEn = 1'b0; tblWrIdx = '0; tblWrValid = 1'b0;
    tblWrBar = '0; tblWrSocBase = '0; tblWrHostOff = '0; tblWrSize = '0;
    reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R1 rspValid in reset", 64'(rspValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: empty table misses; R5: miss outputs zero
    req(58'h0, "R1 lookup on empty table");
    req(58'h808580000000, "R1/R5 empty table miss");
    idle(2);

    wrWin(0, 1'b1, 3'd0, 58'h808580000000, 40'hF5202000, 40'h2000);
    wrWin(1, 1'b1, 3'd4, 58'h800000000000, 40'h2000000000, 40'h1000000000);
    wrWin(2, 1'b1, 3'd4, 58'h0, 40'h0, 40'h1000000000);
    wrWin(3, 1'b1, 3'd0, 58'h8000000000, 40'h0, 40'h20000000);
    wrWin(4, 1'b1, 3'd3, 58'h20008000000000, 40'h0, 40'h20000000);
    wrWin(5, 1'b1, 3'd0, 58'h8000001000, 40'h40000000, 40'h1000);

    // R4: hits, back-to-back (R6)
    req(58'h808580000000, "R4 die1 control window to BAR0");
    req(58'h800000000000, "R4 die1 memory base to BAR4");
    req(58'h800000000010, "R4 interior offset");
    req(58'h0000000ABCD0, "R4 memory window at zero");
    // R2: attribute bits stripped
    req(58'h808580000000 | B56, "R2 bit56 set");
    req(58'h808580000040 | B57, "R2 bit57 set");
    req(58'h800000000010 | B56 | B57, "R2 both flags set");
    // R3: window edges
    req(58'h808580001FFF, "R3 last byte hits");
    req(58'h808580002000, "R3 end is exclusive");
    req(58'h80857FFFFFFF, "R3 below base misses");
    req(58'h0FFFFFFFFF, "R3 last byte of zero window");
    req(58'h1000000000, "R3 end of zero window misses");
    // R8: chip id, its valid flag, die select
    req(58'h20008000000000, "R8 chip id window hit");
    req(58'h20008000000123 | B56, "R8 chip id with flag");
    req(58'h40008000000000, "R8 chip-id valid bit alone misses");
    req(58'h21008000000000, "R8 different chip id misses");
    req(58'h808000000000, "R8 die select moves out of window");
    // R7: overlap, lowest index wins
    req(58'h8000001010, "R7 overlap picks lower index");
    idle(1);

    // R9: write in the same cycle as a request sees old table
    setWr(3, 1'b0, 3'd0, 58'h8000000000, 40'h0, 40'h20000000);
    reqValid = 1'b1;
    reqAddr  = 58'h8000001010;
    expQ.push_back(model(58'h8000001010));
    tagQ.push_back("R9 same-cycle write uses old entry");
    @(negedge clk);
    commitWr(3);
    req(58'h8000001010, "R9 disabled entry falls to next window");
    req(58'h8000000010, "R9 disabled entry no longer hits");
    idle(1);
    wrWin(5, 1'b1, 3'd2, 58'h8000001000, 40'h123400, 40'h1000);
    req(58'h8000001008, "R9 rewritten entry used");
    idle(3);

    check(expQ.size() == 0, "R6 every request answered",
          64'(expQ.size()), 64'd0);
    check(rspValid == 1'b0 && rspHit == 1'b0, "R6 idle after traffic",
          64'({rspValid, rspHit}), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule